// File: doc/BRIEF.md
# Interrupt Steering Aggregator

This block collects a wide vector of level-sensitive interrupt lines and folds them into a small number of output lines. Each output can be switched off on its own. The lines pass through a two-flop synchronizer and are then split into 32-line groups. In each group, every line is gated by its own enable bit, and a software force bit can assert it regardless of the input. The resulting level of each group can be read back.

Groups are paired into outputs of 64 lines each. When the group count is odd, output 0 serves only the lowest 32 lines. Software reaches every register through a simple word-wide read/write bus. Reads return data one cycle after the request.

Register index order is reversed with respect to line numbers: index 0 serves the highest 32 lines. All register addresses are derived from the group count G = NUM_LINES/32.

Top module: `irq_steer_top`

## Requirements
- R1: After reset, every line-enable register, every force register and the control word read zero. The output-disable register reads with its low NUM_MST bits set. Every output is low.
- R2: Register index n of the enable, force and level registers covers lines 32*(G-1-n) up to 32*(G-1-n)+31. Bit b of index n maps to line 32*(G-1-n)+b.
- R3: Each bit of a group level register equals (synchronized line AND enable bit) OR force bit.
- R4: A change on an input line shows in the level registers and the outputs after the second rising clock edge that samples it, and not after the first.
- R5: Line L belongs to output (L+P)/64, where P is 32 when G is odd and 0 when G is even. NUM_MST = ceil(NUM_LINES/64).
- R6: Output k is high when any level bit of its lines is set and bit k of the output-disable register is 0.
- R7: Byte offsets are as follows. The enable register of index n is at 4+4n, the force register at 4G+4+4n and the level register at 8G+4+4n. Output-disable is at 12G+4 and output status at 12G+8. Enable, force and disable registers read back the value written.
- R8: Offset 0 holds a 32-bit control word that reads back the value last written.
- R9: The level registers and output status are read-only. Writes to them, or to unmapped offsets, change no register and no output.
- R10: In output status, bit k equals output k. Bits at NUM_MST and above read zero.
- R11: A read of a misaligned offset, or of any word offset above 12G+8, returns zero.
- R12: Read data is registered. It appears in the cycle after a read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Level interrupt lines, asynchronous to clk |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | (NUM_LINES+63)/64 | Gated aggregated outputs |

## Verification
The bench targets the lines on group and output boundaries (31/32, 95/96, 63/64, 159, 127) in both an odd-group and an even-group instance. A design that ignored group parity, or mapped the register index in ascending line order, would raise the wrong output or the wrong level bit on those lines.

It measures the synchronizer lag at cycle precision, so an extra or missing flop stage is caught. Writes to read-only and unmapped offsets are followed by readback of every writable register and of the outputs, which exposes decode aliasing.

Random enable, force, disable and line patterns check the AND-then-OR ordering against a bench model. They would catch a force bit that was masked, or a disabled output that leaked.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CTRL,
        RK_EN,
        RK_FORCE,
        RK_LEVEL,
        RK_ODIS,
        RK_OSTAT
    } reg_kind_e;

    // Classify a byte offset for a block with g groups.
    function automatic reg_kind_e reg_kind(input int unsigned off, input int unsigned g);
        int unsigned w;
        w = off / 4;
        if (off % 4 != 0)          return RK_NONE;
        if (w == 0)                return RK_CTRL;
        if (w <= g)                return RK_EN;
        if (w <= 2 * g)            return RK_FORCE;
        if (w <= 3 * g)            return RK_LEVEL;
        if (w == 3 * g + 1)        return RK_ODIS;
        if (w == 3 * g + 2)        return RK_OSTAT;
        return RK_NONE;
    endfunction

    // Register index within the enable/force/level banks.
    function automatic int unsigned reg_index(input int unsigned off, input int unsigned g);
        int unsigned w;
        w = off / 4;
        if (w >= 1 && w <= g)          return w - 1;
        if (w > g && w <= 2 * g)       return w - 1 - g;
        if (w > 2 * g && w <= 3 * g)   return w - 1 - 2 * g;
        return 0;
    endfunction

    // Line padding that shrinks output 0 when the group count is odd.
    function automatic int unsigned odd_pad(input int unsigned g);
        return (g % 2 != 0) ? 32 : 0;
    endfunction

    function automatic int unsigned out_lo(input int unsigned k, input int unsigned g);
        return (k == 0) ? 0 : 64 * k - odd_pad(g);
    endfunction

    function automatic int unsigned out_hi(input int unsigned k, input int unsigned g,
                                           input int unsigned lines);
        int unsigned hi;
        hi = 64 * k + 63 - odd_pad(g);
        return (hi > lines - 1) ? lines - 1 : hi;
    endfunction

endpackage

// File: rtl/irq_steer_sync.sv
module irq_steer_sync #(
    parameter int WIDTH = 160
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta_q;
    logic [1:0]       age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
            age_q  <= 2'd0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
            if (age_q != 2'd2) age_q <= age_q + 2'd1;
        end
    end

    // R4: the synchronized copy trails the raw lines by exactly two edges
    assert_sync_lag_R4: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/irq_steer_master.sv
module irq_steer_master #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] lines,
    input  logic             dis,
    output logic             out
);

    logic any_set;

    always_comb begin
        any_set = |lines;
        out     = any_set & ~dis;
    end

endmodule

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
    import irq_steer_pkg::*;
#(
    parameter int NUM_GROUPS = 5,
    parameter int NUM_MST    = 3,
    parameter int ADDR_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr,
    input  logic                        rd,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [31:0]                 wdata,
    input  logic [NUM_GROUPS-1:0][31:0] level_grp,
    input  logic [NUM_MST-1:0]          mst_out,
    output logic [31:0]                 rdata,
    output logic [NUM_GROUPS-1:0][31:0] en_q,
    output logic [NUM_GROUPS-1:0][31:0] force_q,
    output logic [NUM_MST-1:0]          odis_q
);

    localparam int IDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

    reg_kind_e        kind;
    logic [IDX_W-1:0] ix;
    logic [31:0]      ctrl_q;
    logic [31:0]      rd_val;

    always_comb begin
        kind = reg_kind(32'(addr), NUM_GROUPS);
        ix   = IDX_W'(reg_index(32'(addr), NUM_GROUPS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            en_q    <= '0;
            force_q <= '0;
            odis_q  <= '1;
        end else if (wr) begin
            case (kind)
                RK_CTRL:  ctrl_q      <= wdata;
                RK_EN:    en_q[ix]    <= wdata;
                RK_FORCE: force_q[ix] <= wdata;
                RK_ODIS:  odis_q      <= wdata[NUM_MST-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (kind)
            RK_CTRL:  rd_val = ctrl_q;
            RK_EN:    rd_val = en_q[ix];
            RK_FORCE: rd_val = force_q[ix];
            RK_LEVEL: rd_val = level_grp[ix];
            RK_ODIS:  rd_val = 32'(odis_q);
            RK_OSTAT: rd_val = 32'(mst_out);
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= rd_val;
    end

    assert_reset_vals_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_q == '0 && en_q == '0 && force_q == '0 && odis_q == '1));

    assert_ro_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (wr && (kind == RK_LEVEL || kind == RK_OSTAT || kind == RK_NONE)) |=>
        ($stable(en_q) && $stable(force_q) && $stable(odis_q) && $stable(ctrl_q)));

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (rd && kind == RK_NONE) |=> (rdata == '0));

    assert_ctrl_readback_R8: assert property (@(posedge clk) disable iff (rst)
        (wr && kind == RK_CTRL) |=> (ctrl_q == $past(wdata)));

endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
    import irq_steer_pkg::*;
#(
    parameter int NUM_LINES = 160,
    parameter int ADDR_W    = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_LINES-1:0]         irq_in,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    output logic [(NUM_LINES+63)/64-1:0] irq_out
);

    localparam int NUM_GROUPS = NUM_LINES / 32;
    localparam int NUM_MST    = (NUM_LINES + 63) / 64;
    localparam int OSTAT_OFF  = 12 * NUM_GROUPS + 8;

    logic [NUM_LINES-1:0]         in_s;
    logic [NUM_LINES-1:0]         level_lines;
    logic [NUM_GROUPS-1:0][31:0]  level_grp;
    logic [NUM_GROUPS-1:0][31:0]  en_q;
    logic [NUM_GROUPS-1:0][31:0]  force_q;
    logic [NUM_MST-1:0]           odis_q;

    irq_steer_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_in),
        .q   (in_s)
    );

    irq_steer_regs #(
        .NUM_GROUPS (NUM_GROUPS),
        .NUM_MST    (NUM_MST),
        .ADDR_W     (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .level_grp (level_grp),
        .mst_out   (irq_out),
        .rdata     (bus_rdata),
        .en_q      (en_q),
        .force_q   (force_q),
        .odis_q    (odis_q)
    );

    // Register index g serves the lines counted down from the top.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int BASE = 32 * (NUM_GROUPS - 1 - g);
        assign level_grp[g] = (in_s[BASE +: 32] & en_q[g]) | force_q[g];
        assign level_lines[BASE +: 32] = level_grp[g];
    end

    for (genvar k = 0; k < NUM_MST; k++) begin : g_mst
        localparam int LO = out_lo(k, NUM_GROUPS);
        localparam int HI = out_hi(k, NUM_GROUPS, NUM_LINES);
        irq_steer_master #(.WIDTH(HI - LO + 1)) u_mst (
            .lines (level_lines[HI:LO]),
            .dis   (odis_q[k]),
            .out   (irq_out[k])
        );
    end

    // R10: output status read returns the live outputs, upper bits zero
    assert_ostat_read_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(OSTAT_OFF)) |=> (bus_rdata == 32'($past(irq_out))));

endmodule

// File: tb/irq_steer_top_tb.sv
module irq_steer_top_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [159:0] lines_a = '0;
    logic [127:0] lines_b = '0;
    logic         wr_a = 1'b0, wr_b = 1'b0, rd_a = 1'b0, rd_b = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata_a, rdata_b;
    logic [2:0]   out_a;
    logic [1:0]   out_b;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [31:0] en_m    [2][5];
    logic [31:0] force_m [2][5];
    logic [3:0]  odis_m  [2];

    always #10 clk = ~clk;

    irq_steer_top #(.NUM_LINES(160), .ADDR_W(8)) u_dut (
        .clk(clk), .rst(rst), .irq_in(lines_a), .bus_wr(wr_a), .bus_rd(rd_a),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_a), .irq_out(out_a));

    irq_steer_top #(.NUM_LINES(128), .ADDR_W(8)) u_dut_even (
        .clk(clk), .rst(rst), .irq_in(lines_b), .bus_wr(wr_b), .bus_rd(rd_b),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_b), .irq_out(out_b));

    function automatic int ng(int d); return (d == 0) ? 5 : 4; endfunction
    function automatic int nm(int d); return (d == 0) ? 3 : 2; endfunction
    function automatic int off_en(int d, int n);    return 4 + 4 * n; endfunction
    function automatic int off_force(int d, int n); return 4 * ng(d) + 4 + 4 * n; endfunction
    function automatic int off_level(int d, int n); return 8 * ng(d) + 4 + 4 * n; endfunction
    function automatic int off_odis(int d);         return 12 * ng(d) + 4; endfunction
    function automatic int off_ostat(int d);        return 12 * ng(d) + 8; endfunction

    function automatic logic [159:0] cur_lines(int d);
        return (d == 0) ? lines_a : {32'b0, lines_b};
    endfunction

    function automatic logic [31:0] exp_level(int d, int n);
        logic [159:0] l;
        int base;
        l = cur_lines(d);
        base = 32 * (ng(d) - 1 - n);
        return (l[base +: 32] & en_m[d][n]) | force_m[d][n];
    endfunction

    function automatic logic [3:0] exp_out(int d);
        logic [3:0] o;
        logic [31:0] s;
        int pad;
        o = '0;
        pad = (ng(d) % 2 != 0) ? 32 : 0;
        for (int n = 0; n < ng(d); n++) begin
            s = exp_level(d, n);
            for (int b = 0; b < 32; b++) begin
                int line;
                line = 32 * (ng(d) - 1 - n) + b;
                if (s[b]) o[(line + pad) / 64] = 1'b1;
            end
        end
        return o & ~odis_m[d] & ((4'd1 << nm(d)) - 4'd1);
    endfunction

    function automatic logic [3:0] out_now(int d);
        return (d == 0) ? {1'b0, out_a} : {2'b0, out_b};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(int d, int off, logic [31:0] v);
        @(negedge clk);
        addr = 8'(off);
        wdata = v;
        if (d == 0) wr_a = 1'b1; else wr_b = 1'b1;
        @(negedge clk);
        wr_a = 1'b0;
        wr_b = 1'b0;
    endtask

    task automatic bus_read(int d, int off, output logic [31:0] v);
        @(negedge clk);
        addr = 8'(off);
        if (d == 0) rd_a = 1'b1; else rd_b = 1'b1;
        @(negedge clk);
        rd_a = 1'b0;
        rd_b = 1'b0;
        v = (d == 0) ? rdata_a : rdata_b;
    endtask

    task automatic put_en(int d, int n, logic [31:0] v);
        en_m[d][n] = v; bus_write(d, off_en(d, n), v);
    endtask
    task automatic put_force(int d, int n, logic [31:0] v);
        force_m[d][n] = v; bus_write(d, off_force(d, n), v);
    endtask
    task automatic put_odis(int d, logic [3:0] v);
        odis_m[d] = v & ((4'd1 << nm(d)) - 4'd1); bus_write(d, off_odis(d), 32'(v));
    endtask

    task automatic set_line(int d, int line);
        if (d == 0) begin lines_a = '0; lines_a[line] = 1'b1; end
        else begin lines_b = '0; lines_b[line] = 1'b1; end
    endtask

    task automatic line_case(int d, int line, int kexp);
        logic [31:0] v;
        int n;
        set_line(d, line);
        repeat (3) @(negedge clk);
        n = ng(d) - 1 - line / 32;
        bus_read(d, off_level(d, n), v);
        chk($sformatf("R2 line %0d level idx %0d", line, n), v, 32'd1 << (line % 32));
        chk($sformatf("R5 line %0d output", line), 32'(out_now(d)), 32'd1 << kexp);
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] keep;
        void'($urandom(32'h5eed_0042));
        for (int d = 0; d < 2; d++) begin
            for (int n = 0; n < 5; n++) begin en_m[d][n] = '0; force_m[d][n] = '0; end
        end
        odis_m[0] = 4'h7;
        odis_m[1] = 4'h3;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int d = 0; d < 2; d++) begin
            chk("R1 outputs low", 32'(out_now(d)), 32'd0);
            bus_read(d, 0, v); chk("R1 control", v, 32'd0);
            for (int n = 0; n < ng(d); n++) begin
                bus_read(d, off_en(d, n), v);    chk("R1 enable", v, 32'd0);
                bus_read(d, off_force(d, n), v); chk("R1 force", v, 32'd0);
            end
            bus_read(d, off_odis(d), v);  chk("R1 disable", v, 32'((4'd1 << nm(d)) - 4'd1));
            bus_read(d, off_ostat(d), v); chk("R1 output status", v, 32'd0);
        end

        // R8 control readback, R12 read data holds
        bus_write(0, 0, 32'hA5A5_1234);
        bus_read(0, 0, v); chk("R8 control A", v, 32'hA5A5_1234);
        bus_write(1, 0, 32'h0F0F_8001);
        bus_read(1, 0, v); chk("R8 control B", v, 32'h0F0F_8001);
        bus_write(0, 0, 32'h1111_2222);
        repeat (2) @(negedge clk);
        chk("R12 rdata holds without read", rdata_a, 32'hA5A5_1234);

        // R11 unmapped reads
        bus_read(0, 72, v);  chk("R11 past end A", v, 32'd0);
        bus_read(0, 2, v);   chk("R11 misaligned", v, 32'd0);
        bus_read(0, 252, v); chk("R11 far offset", v, 32'd0);
        bus_read(1, 60, v);  chk("R11 past end B", v, 32'd0);

        // R4 synchronizer lag on line 34 (index 3 bit 2, output 1)
        put_en(0, 3, 32'h4);
        put_odis(0, 4'b0101);
        lines_a = '0;
        lines_a[34] = 1'b1;
        @(negedge clk);
        chk("R4 no output after one edge", 32'(out_a), 32'd0);
        @(negedge clk);
        chk("R4 output after two edges", 32'(out_a), 32'b010);
        lines_a = '0;
        @(negedge clk);
        chk("R4 still high one edge after drop", 32'(out_a), 32'b010);
        @(negedge clk);
        chk("R4 low two edges after drop", 32'(out_a), 32'd0);

        // R2 / R5 boundary lines
        for (int d = 0; d < 2; d++) begin
            for (int n = 0; n < ng(d); n++) put_en(d, n, 32'hFFFF_FFFF);
            put_odis(d, 4'h0);
        end
        line_case(0, 0, 0);   line_case(0, 31, 0);  line_case(0, 32, 1);
        line_case(0, 95, 1);  line_case(0, 96, 2);  line_case(0, 159, 2);
        line_case(1, 0, 0);   line_case(1, 63, 0);  line_case(1, 64, 1);
        line_case(1, 127, 1);

        // R9 writes to read-only and unmapped offsets are ignored
        lines_a = '0;
        lines_a[70] = 1'b1;
        put_force(0, 1, 32'h0000_0100);
        repeat (3) @(negedge clk);
        keep = 32'(out_a);
        bus_write(0, off_level(0, 1), 32'hFFFF_FFFF);
        bus_write(0, off_ostat(0), 32'hFFFF_FFFF);
        bus_write(0, 76, 32'hFFFF_FFFF);
        bus_read(0, off_en(0, 1), v);    chk("R9 enable untouched", v, en_m[0][1]);
        bus_read(0, off_force(0, 1), v); chk("R9 force untouched", v, force_m[0][1]);
        bus_read(0, off_odis(0), v);     chk("R9 disable untouched", v, 32'(odis_m[0]));
        bus_read(0, off_level(0, 1), v); chk("R9 level unchanged", v, exp_level(0, 1));
        bus_read(0, 0, v);               chk("R9 control untouched", v, 32'h1111_2222);
        chk("R9 outputs unchanged", 32'(out_a), keep);

        // R3 / R6 / R7 / R10 random patterns
        for (int it = 0; it < 30; it++) begin
            for (int d = 0; d < 2; d++) begin
                logic [159:0] r;
                r = {$urandom, $urandom, $urandom, $urandom, $urandom};
                if (it % 3 != 0) r = r & {$urandom, $urandom, $urandom, $urandom, $urandom}
                                       & {$urandom, $urandom, $urandom, $urandom, $urandom};
                if (it % 5 == 4) r = '0;
                for (int n = 0; n < ng(d); n++) begin
                    put_en(d, n, (it % 4 == 0) ? $urandom & $urandom : $urandom);
                    put_force(d, n, (it % 2 == 0) ? 32'd0 : $urandom & $urandom & $urandom & $urandom);
                end
                put_odis(d, 4'($urandom));
                if (d == 0) lines_a = r; else lines_b = r[127:0];
                repeat (3) @(negedge clk);
                for (int n = 0; n < ng(d); n++) begin
                    bus_read(d, off_level(d, n), v);
                    chk($sformatf("R3 level d%0d idx %0d", d, n), v, exp_level(d, n));
                    bus_read(d, off_en(d, n), v);
                    chk($sformatf("R7 enable readback d%0d idx %0d", d, n), v, en_m[d][n]);
                    bus_read(d, off_force(d, n), v);
                    chk($sformatf("R7 force readback d%0d idx %0d", d, n), v, force_m[d][n]);
                end
                bus_read(d, off_odis(d), v);
                chk("R7 disable readback", v, 32'(odis_m[d]));
                chk($sformatf("R6 outputs d%0d", d), 32'(out_now(d)), 32'(exp_out(d)));
                bus_read(d, off_ostat(d), v);
                chk("R10 output status", v, 32'(exp_out(d)));
            end
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule